// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

A first-in first-out buffer that carries 9-bit words from a write clock domain to an independent read clock domain. The depth is a parameter (256 words by default, a power of two of at least 16). The producer pushes a word on each write-clock edge at which `wrEn` is high. The consumer pops a word on each read-clock edge at which `rdEn` is high, and the word appears on `rdData` after that edge. Four active-low status flags report the fill level. Full and almost-full are registered on the write clock. Empty and almost-empty are registered on the read clock.

The almost-full threshold sits a programmable number of words (the full offset, m) below full. The almost-empty threshold sits a programmable number of words (the empty offset, n) above empty. Both offsets reset to 7. They are loaded through a small strobe port on the write clock and are meant to be changed while traffic is idle. Pointers cross between domains as Gray codes through two-stage synchronisers. Each side's flags are therefore conservative: a side may briefly see a stale count, but it never overruns or underruns the buffer. A two-channel arrangement is made from two independent instances.

Top module: `tflag_fifo`

## Requirements
- R1: While `rstN` is low and after its release, `fullN` and `almostFullN` are 1, `emptyN` and `almostEmptyN` are 0, and `rdData` is 0.
- R2: Words are read out in the order they were written, and each word is unchanged.
- R3: With no reads pending, `fullN` goes to 0 at the write-clock edge that stores the DEPTH-th word, and stays 1 while the count is below DEPTH.
- R4: A write presented while `fullN` is 0 is ignored. The write pointer does not move, `fullN` stays 0, and the dropped word never appears at the output.
- R5: `emptyN` is 0 exactly when no words are held (once synchronised). A read presented while `emptyN` is 0 leaves `rdData` and the read pointer unchanged.
- R6: `almostFullN` is 0 when the count is at least DEPTH−m and 1 when it is below that. It is therefore always 0 while `fullN` is 0.
- R7: `almostEmptyN` is 0 for counts 0 to n and 1 for counts of n+1 or more. It is therefore always 0 while `emptyN` is 0.
- R8: Without any offset load, m = n = 7. Almost-full asserts at DEPTH−7 words and almost-empty releases at 8 words.
- R9: A write-clock edge with `offLoad` = 1 stores `offData` into the full offset when `offSel` = 1, or into the empty offset when `offSel` = 0. The new value governs the flags from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrEn | input | 1 | Write request, sampled on wrClk |
| wrData | input | WIDTH (9) | Word to store |
| rdEn | input | 1 | Read request, sampled on rdClk |
| rdData | output | WIDTH (9) | Most recently read word |
| offLoad | input | 1 | Offset load strobe, sampled on wrClk |
| offSel | input | 1 | 1 selects the full offset, 0 selects the empty offset |
| offData | input | log2(DEPTH) | Offset value to load |
| fullN | output | 1 | Active-low full flag (write domain) |
| almostFullN | output | 1 | Active-low almost-full flag (write domain) |
| emptyN | output | 1 | Active-low empty flag (read domain) |
| almostEmptyN | output | 1 | Active-low almost-empty flag (read domain) |

## Verification
The hardest case to reach is a write presented while the buffer is genuinely full. The stimulus must first push exactly DEPTH words with no reads, so that the write-side count is not clouded by synchroniser lag. The bench does this and checks the flags at the threshold counts DEPTH−8, DEPTH−7, DEPTH−1 and DEPTH. It then offers one extra word and drains all DEPTH words to show that the extra word was dropped. The almost-empty boundary depends on the cross-domain lag. The bench therefore lets both clocks run idle for several cycles before it checks any read-side flag, and it repeats the boundary checks with reprogrammed offsets.

// File: rtl/tflag_fifo_pkg.sv
package tflag_fifo_pkg;

  // Offset value both threshold registers take at reset
  localparam int DEF_OFFSET = 7;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrStrobe;  // store wrData at wrAddr this wrClk edge
    logic rdStrobe;  // fetch rdAddr into rdData this rdClk edge
  } fifo_strobe_t;

endpackage

// File: rtl/tflag_fifo_sync.sv
module tflag_fifo_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage[s] <= '0;
      end else if (s == 0) begin
        stage[s] <= din;
      end else begin
        stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/tflag_fifo_ctrl.sv
module tflag_fifo_ctrl
  import tflag_fifo_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                       wrClk,
  input  logic                       rdClk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic                       offLoad,
  input  logic                       offSel,
  input  logic [$clog2(DEPTH)-1:0]   offData,
  output fifo_strobe_t               strobes,
  output logic [$clog2(DEPTH)-1:0]   wrAddr,
  output logic [$clog2(DEPTH)-1:0]   rdAddr,
  output logic                       fullN,
  output logic                       almostFullN,
  output logic                       emptyN,
  output logic                       almostEmptyN
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  function automatic logic [CW-1:0] toGray(input logic [CW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CW-1:0] fromGray(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW-2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // ---------------- offset registers (write domain) ----------------
  logic [AW-1:0] fullOff;
  logic [AW-1:0] emptyOff;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      fullOff  <= AW'(DEF_OFFSET);
      emptyOff <= AW'(DEF_OFFSET);
    end else if (offLoad) begin
      if (offSel) fullOff  <= offData;
      else        emptyOff <= offData;
    end
  end

  // ---------------- write domain ----------------
  logic [CW-1:0] wBin, wGray, wBinNext, wCount;
  logic [CW-1:0] rGraySyncW, rBinW;
  logic          wrAccept;

  tflag_fifo_sync #(.WIDTH(CW), .STAGES(2)) u_syncRtoW (
    .clk(wrClk), .rstN(rstN), .din(rGray), .dout(rGraySyncW)
  );

  assign rBinW    = fromGray(rGraySyncW);
  assign wrAccept = wrEn & fullN;
  assign wBinNext = wBin + CW'(wrAccept);
  assign wCount   = wBinNext - rBinW;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wBin        <= '0;
      wGray       <= '0;
      fullN       <= 1'b1;
      almostFullN <= 1'b1;
    end else begin
      wBin        <= wBinNext;
      wGray       <= toGray(wBinNext);
      fullN       <= (wCount != DEPTH_C);
      almostFullN <= (wCount < (DEPTH_C - {1'b0, fullOff}));
    end
  end

  // ---------------- read domain ----------------
  logic [CW-1:0] rBin, rGray, rBinNext, rCount;
  logic [CW-1:0] wGraySyncR, wBinR;
  logic          rdAccept;

  tflag_fifo_sync #(.WIDTH(CW), .STAGES(2)) u_syncWtoR (
    .clk(rdClk), .rstN(rstN), .din(wGray), .dout(wGraySyncR)
  );

  assign wBinR    = fromGray(wGraySyncR);
  assign rdAccept = rdEn & emptyN;
  assign rBinNext = rBin + CW'(rdAccept);
  assign rCount   = wBinR - rBinNext;

  // emptyOff is quasi-static: loaded only while traffic is idle
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rBin         <= '0;
      rGray        <= '0;
      emptyN       <= 1'b0;
      almostEmptyN <= 1'b0;
    end else begin
      rBin         <= rBinNext;
      rGray        <= toGray(rBinNext);
      emptyN       <= (rCount != '0);
      almostEmptyN <= (rCount > {1'b0, emptyOff});
    end
  end

  assign strobes.wrStrobe = wrAccept;
  assign strobes.rdStrobe = rdAccept;
  assign wrAddr = wBin[AW-1:0];
  assign rdAddr = rBin[AW-1:0];

endmodule

// File: rtl/tflag_fifo_dpath.sv
module tflag_fifo_dpath
  import tflag_fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 9
) (
  input  logic                     wrClk,
  input  logic                     rdClk,
  input  logic                     rstN,
  input  fifo_strobe_t             strobes,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  input  logic [WIDTH-1:0]         wrData,
  output logic [WIDTH-1:0]         rdData
);

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobes.wrStrobe) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)                 rdData <= '0;
    else if (strobes.rdStrobe) rdData <= store[rdAddr];
  end

endmodule

// File: rtl/tflag_fifo.sv
module tflag_fifo
  import tflag_fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 9
) (
  input  logic                     wrClk,
  input  logic                     rdClk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [WIDTH-1:0]         wrData,
  input  logic                     rdEn,
  output logic [WIDTH-1:0]         rdData,
  input  logic                     offLoad,
  input  logic                     offSel,
  input  logic [$clog2(DEPTH)-1:0] offData,
  output logic                     fullN,
  output logic                     almostFullN,
  output logic                     emptyN,
  output logic                     almostEmptyN
);

  fifo_strobe_t             strobes;
  logic [$clog2(DEPTH)-1:0] wrAddr;
  logic [$clog2(DEPTH)-1:0] rdAddr;

  tflag_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn(wrEn), .rdEn(rdEn),
    .offLoad(offLoad), .offSel(offSel), .offData(offData),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .almostFullN(almostFullN),
    .emptyN(emptyN), .almostEmptyN(almostEmptyN)
  );

  tflag_fifo_dpath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dpath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: rtl/tflag_fifo_chk.sv
module tflag_fifo_chk #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 9
) (
  input logic                     wrClk,
  input logic                     rdClk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic                     rdEn,
  input logic                     fullN,
  input logic                     almostFullN,
  input logic                     emptyN,
  input logic                     almostEmptyN,
  input logic [$clog2(DEPTH)-1:0] wrAddr,
  input logic [$clog2(DEPTH)-1:0] rdAddr,
  input logic [WIDTH-1:0]         rdData
);

  // R4: a write offered while full does not move the write pointer
  a_r4_no_write_when_full: assert property (
    @(posedge wrClk) disable iff (!rstN)
    (!fullN && wrEn) |=> $stable(wrAddr)
  );

  // R5: a read offered while empty moves neither the pointer nor the data
  a_r5_no_read_when_empty: assert property (
    @(posedge rdClk) disable iff (!rstN)
    (!emptyN && rdEn) |=> ($stable(rdAddr) && $stable(rdData))
  );

  // R6: full implies almost-full
  a_r6_full_in_almost_full: assert property (
    @(posedge wrClk) disable iff (!rstN)
    !fullN |-> !almostFullN
  );

  // R7: empty implies almost-empty
  a_r7_empty_in_almost_empty: assert property (
    @(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !almostEmptyN
  );

endmodule

bind tflag_fifo tflag_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .wrEn(wrEn), .rdEn(rdEn),
  .fullN(fullN), .almostFullN(almostFullN),
  .emptyN(emptyN), .almostEmptyN(almostEmptyN),
  .wrAddr(wrAddr), .rdAddr(rdAddr), .rdData(rdData)
);

// File: tb/tb_tflag_fifo.sv
module tb_tflag_fifo;

  localparam int DEPTH = 256;
  localparam int WIDTH = 9;
  localparam int AW    = $clog2(DEPTH);

  logic             wrClk = 1'b0;
  logic             rdClk = 1'b0;
  logic             rstN  = 1'b0;
  logic             wrEn  = 1'b0;
  logic             rdEn  = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic             offLoad = 1'b0;
  logic             offSel  = 1'b0;
  logic [AW-1:0]    offData = '0;
  logic [WIDTH-1:0] rdData;
  logic             fullN, almostFullN, emptyN, almostEmptyN;

  always #10 wrClk = ~wrClk;   // 50 MHz write clock
  always #17 rdClk = ~rdClk;   // unrelated read clock

  tflag_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .offLoad(offLoad), .offSel(offSel), .offData(offData),
    .fullN(fullN), .almostFullN(almostFullN),
    .emptyN(emptyN), .almostEmptyN(almostEmptyN)
  );

  int checks = 0;
  int fails  = 0;
  logic [WIDTH-1:0] model [$];
  logic [WIDTH-1:0] nextVal = 9'd1;

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic rawWrite(input logic [WIDTH-1:0] d);
    @(negedge wrClk);
    wrEn = 1'b1; wrData = d;
    @(posedge wrClk); #1;
    wrEn = 1'b0;
  endtask

  task automatic pushWord();
    model.push_back(nextVal);
    rawWrite(nextVal);
    nextVal = nextVal + 9'd37;
  endtask

  task automatic rawRead();
    @(negedge rdClk);
    rdEn = 1'b1;
    @(posedge rdClk); #1;
    rdEn = 1'b0;
  endtask

  task automatic popCheck(input string req);
    logic [WIDTH-1:0] exp;
    exp = model.pop_front();
    rawRead();
    check(req, "read word", int'(rdData), int'(exp));
  endtask

  task automatic settle();
    repeat (6) @(posedge rdClk);
    repeat (6) @(posedge wrClk);
    #1;
  endtask

  task automatic loadOffset(input logic sel, input logic [AW-1:0] v);
    @(negedge wrClk);
    offLoad = 1'b1; offSel = sel; offData = v;
    @(posedge wrClk); #1;
    offLoad = 1'b0;
    settle();
  endtask

  // ---- scenarios ----
  task automatic testReset();
    check("R1", "fullN after reset", int'(fullN), 1);
    check("R1", "almostFullN after reset", int'(almostFullN), 1);
    check("R1", "emptyN after reset", int'(emptyN), 0);
    check("R1", "almostEmptyN after reset", int'(almostEmptyN), 0);
    check("R1", "rdData after reset", int'(rdData), 0);
  endtask

  task automatic testDefaultAlmostEmpty();
    for (int i = 0; i < 7; i++) pushWord();
    settle();
    check("R5", "emptyN at 7 words", int'(emptyN), 1);
    check("R8", "almostEmptyN at 7 words (n=7)", int'(almostEmptyN), 0);
    pushWord();
    settle();
    check("R7", "almostEmptyN at 8 words", int'(almostEmptyN), 1);
    for (int i = 0; i < 8; i++) popCheck("R2");
    settle();
    check("R5", "emptyN after drain", int'(emptyN), 0);
    check("R7", "almostEmptyN after drain", int'(almostEmptyN), 0);
  endtask

  task automatic testReadWhenEmpty();
    logic [WIDTH-1:0] held;
    held = rdData;
    rawRead();
    check("R5", "rdData held on empty read", int'(rdData), int'(held));
    settle();
    check("R5", "emptyN still low", int'(emptyN), 0);
    pushWord();
    settle();
    popCheck("R5");  // pointer did not move: first stored word comes out
  endtask

  task automatic testFill();
    for (int k = 1; k <= DEPTH; k++) begin
      pushWord();
      if (k == DEPTH-8) begin
        check("R6", "almostFullN at DEPTH-8", int'(almostFullN), 1);
        check("R3", "fullN at DEPTH-8", int'(fullN), 1);
      end
      if (k == DEPTH-7) check("R8", "almostFullN at DEPTH-7 (m=7)", int'(almostFullN), 0);
      if (k == DEPTH-1) check("R3", "fullN at DEPTH-1", int'(fullN), 1);
      if (k == DEPTH) begin
        check("R3", "fullN at DEPTH", int'(fullN), 0);
        check("R6", "almostFullN at DEPTH", int'(almostFullN), 0);
      end
    end
    rawWrite(9'h1AA);
    check("R4", "fullN after write while full", int'(fullN), 0);
    settle();
    check("R7", "almostEmptyN when full", int'(almostEmptyN), 1);
    for (int i = 0; i < DEPTH; i++) popCheck("R2");
    settle();
    check("R4", "emptyN after draining DEPTH words", int'(emptyN), 0);
    check("R6", "almostFullN after drain", int'(almostFullN), 1);
    check("R3", "fullN after drain", int'(fullN), 1);
  endtask

  task automatic testOffsetLoad();
    loadOffset(1'b1, AW'(2));   // full offset m = 2
    loadOffset(1'b0, AW'(3));   // empty offset n = 3
    for (int i = 0; i < 3; i++) pushWord();
    settle();
    check("R9", "almostEmptyN at 3 words (n=3)", int'(almostEmptyN), 0);
    pushWord();
    settle();
    check("R9", "almostEmptyN at 4 words (n=3)", int'(almostEmptyN), 1);
    for (int k = 5; k <= DEPTH-3; k++) pushWord();
    check("R9", "almostFullN at DEPTH-3 (m=2)", int'(almostFullN), 1);
    pushWord();
    check("R9", "almostFullN at DEPTH-2 (m=2)", int'(almostFullN), 0);
    check("R3", "fullN at DEPTH-2", int'(fullN), 1);
    for (int i = 0; i < DEPTH-2; i++) popCheck("R2");
    settle();
    check("R5", "emptyN after offset drain", int'(emptyN), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge wrClk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge wrClk);
    #1;
    testReset();
    rstN = 1'b1;
    settle();
    testReset();
    testDefaultAlmostEmpty();
    testReadWhenEmpty();
    testFill();
    testOffsetLoad();
    summary();
    $finish;
  end

endmodule